// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block turns a 20-bit byte address from a 16-bit processor into chip selects for a memory built from 32K×8 devices. The data bus is split into two byte banks. The even bank carries D7–D0 and is keyed by address bit 0. The odd bank carries D15–D8 and is keyed by the active-low bus-high-enable input. Each pair of chips (one even, one odd) covers a 64 KiB window. The fixed map holds one ROM pair at the top of the address space, so that the reset fetch lands in ROM, and two RAM pairs directly below it.

The decoder is purely combinational. Selects are driven only while a read or write strobe is low. Every chip receives address bits 15 down to 1 as its word address. The block also reports which byte lanes the current cycle uses. It raises an error flag for an access that hits no region, and for a write aimed at ROM.

Top module: `memdec_top`

## Requirements
- R1: An even-bank (low) select is driven low only when address bit 0 is 0.
- R2: An odd-bank (high) select is driven low only when bhe_n_i is 0.
- R3: lane_lo_o is high exactly when address bit 0 is 0, and lane_hi_o is high exactly when bhe_n_i is 0. Both high means a word transfer, low lane only means a byte on D7–D0, and high lane only means a byte on D15–D8. The lane outputs do not depend on the strobes.
- R4: A read in F0000h–FFFFFh, including the reset fetch at FFFF0h, selects the ROM pair.
- R5: A read or write in D0000h–DFFFFh selects RAM pair 0. A read or write in E0000h–EFFFFh selects RAM pair 1.
- R6: A write strobe into the ROM window drives every select high and raises decode_err_o. This also applies when the read strobe is low at the same time.
- R7: An access whose address lies below D0000h drives every select high and raises decode_err_o.
- R8: With both strobes high, every select is high and decode_err_o is low, whatever the address.
- R9: chip_addr_o always equals address bits 15 down to 1.
- R10: At most one chip pair has any select low at a time. With address bit 0 at 1 and bhe_n_i at 1, no select is low and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Processor byte address |
| bhe_n_i | input | 1 | Active-low enable for the high byte lane |
| rd_n_i | input | 1 | Active-low memory read strobe |
| wr_n_i | input | 1 | Active-low memory write strobe |
| chip_addr_o | output | 15 | Word address to every chip (address bits 15:1) |
| rom_cs_lo_n_o | output | 1 | ROM even-bank select, active low |
| rom_cs_hi_n_o | output | 1 | ROM odd-bank select, active low |
| ram_cs_lo_n_o | output | 2 | RAM even-bank selects per pair, active low |
| ram_cs_hi_n_o | output | 2 | RAM odd-bank selects per pair, active low |
| lane_lo_o | output | 1 | Low byte lane in use |
| lane_hi_o | output | 1 | High byte lane in use |
| decode_err_o | output | 1 | Access hit no region, or wrote to ROM |

## Verification
The assertions are evaluated whenever an input changes. They check the following:
- No even select falls while address bit 0 is set.
- No odd select falls while bhe_n_i is high.
- At most one pair is selected.
- An error or an idle bus leaves every select high.

These checks are local, so they cannot tell whether the right pair is selected. Only the bench's vectors show that. The vectors cover the region boundaries, the reset fetch address, all lane combinations, a write into ROM with both strobes low, and unmapped addresses.

// File: rtl/memdec_pkg.sv
// Shared types for the banked memory decoder.
// Assumes a two-lane (even/odd) byte-banked bus.
package memdec_pkg;
    typedef struct packed {
        logic hi;   // odd bank, D15..D8
        logic lo;   // even bank, D7..D0
    } lane_t;
endpackage

// File: rtl/memdec_lanes.sv
// Byte-lane decoder: derives which banks the cycle uses from address
// bit 0 and the active-low high-enable. Assumes both inputs are stable.
module memdec_lanes
    import memdec_pkg::*;
(
    input  logic  a0,
    input  logic  bhe_n,
    output lane_t lanes
);
    // Each lane is enabled by its own key signal only.
    always_comb begin
        lanes.lo = ~a0;
        lanes.hi = ~bhe_n;
    end
endmodule

// File: rtl/memdec_region.sv
// Region decoder: compares the address tag (bits above one pair's
// window) against the fixed ROM tag and a run of consecutive RAM tags.
// Assumes the RAM tags do not overlap the ROM tag.
module memdec_region #(
    parameter int TAG_W   = 4,
    parameter int NUM_RAM = 2,
    parameter int ROM_TAG = 15,
    parameter int RAM_TAG = 13
) (
    input  logic [TAG_W-1:0]   tag,
    output logic               rom_hit,
    output logic [NUM_RAM-1:0] ram_hit,
    output logic               unmapped
);
    // ROM window compare.
    always_comb rom_hit = (tag == TAG_W'(ROM_TAG));

    // One compare per RAM pair, at consecutive tags.
    for (genvar k = 0; k < NUM_RAM; k++) begin : g_ram
        always_comb ram_hit[k] = (tag == TAG_W'(RAM_TAG + k));
    end

    // Anything matching no window is unmapped.
    always_comb unmapped = !rom_hit && !(|ram_hit);
endmodule

// File: rtl/memdec_select.sv
// Select generator: gates region hits with the strobes and the lanes
// to form active-low chip selects, and flags bad accesses.
// Assumes ROM is read-only, so a write to it is an error.
module memdec_select
    import memdec_pkg::*;
#(
    parameter int NUM_RAM = 2
) (
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               rom_hit,
    input  logic [NUM_RAM-1:0] ram_hit,
    input  logic               unmapped,
    input  lane_t              lanes,
    output logic               rom_cs_lo_n,
    output logic               rom_cs_hi_n,
    output logic [NUM_RAM-1:0] ram_cs_lo_n,
    output logic [NUM_RAM-1:0] ram_cs_hi_n,
    output logic               decode_err
);
    logic access;
    logic rom_ok;

    // A cycle is live while either strobe is low.
    always_comb access = !rd_n || !wr_n;

    // ROM is usable only for pure reads.
    always_comb rom_ok = access && rom_hit && wr_n;

    // ROM selects per lane.
    always_comb begin
        rom_cs_lo_n = !(rom_ok && lanes.lo);
        rom_cs_hi_n = !(rom_ok && lanes.hi);
    end

    // RAM selects per pair and lane.
    for (genvar k = 0; k < NUM_RAM; k++) begin : g_pair
        always_comb begin
            ram_cs_lo_n[k] = !(access && ram_hit[k] && lanes.lo);
            ram_cs_hi_n[k] = !(access && ram_hit[k] && lanes.hi);
        end
    end

    // Error: a live cycle that is unmapped or writes ROM.
    always_comb decode_err = access && (unmapped || (rom_hit && !wr_n));
endmodule

// File: rtl/memdec_top.sv
// Banked memory chip-select decoder, top level.
// Purely combinational. Each chip pair spans 2**(CHIP_AW+1) bytes.
// The word address to the chips is address bits CHIP_AW..1.
module memdec_top
    import memdec_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int CHIP_AW = 15,
    parameter int NUM_RAM = 2,
    parameter int ROM_TAG = 15,
    parameter int RAM_TAG = 13
) (
    input  logic               [ADDR_W-1:0] addr_i,
    input  logic                            bhe_n_i,
    input  logic                            rd_n_i,
    input  logic                            wr_n_i,
    output logic              [CHIP_AW-1:0] chip_addr_o,
    output logic                            rom_cs_lo_n_o,
    output logic                            rom_cs_hi_n_o,
    output logic              [NUM_RAM-1:0] ram_cs_lo_n_o,
    output logic              [NUM_RAM-1:0] ram_cs_hi_n_o,
    output logic                            lane_lo_o,
    output logic                            lane_hi_o,
    output logic                            decode_err_o
);
    localparam int TAG_W = ADDR_W - CHIP_AW - 1;

    lane_t              lanes;
    logic               rom_hit;
    logic [NUM_RAM-1:0] ram_hit;
    logic               unmapped;

    // Word address shared by every chip.
    always_comb chip_addr_o = addr_i[CHIP_AW:1];

    memdec_lanes u_lanes (
        .a0    (addr_i[0]),
        .bhe_n (bhe_n_i),
        .lanes (lanes)
    );

    memdec_region #(
        .TAG_W   (TAG_W),
        .NUM_RAM (NUM_RAM),
        .ROM_TAG (ROM_TAG),
        .RAM_TAG (RAM_TAG)
    ) u_region (
        .tag      (addr_i[ADDR_W-1 -: TAG_W]),
        .rom_hit  (rom_hit),
        .ram_hit  (ram_hit),
        .unmapped (unmapped)
    );

    memdec_select #(
        .NUM_RAM (NUM_RAM)
    ) u_select (
        .rd_n        (rd_n_i),
        .wr_n        (wr_n_i),
        .rom_hit     (rom_hit),
        .ram_hit     (ram_hit),
        .unmapped    (unmapped),
        .lanes       (lanes),
        .rom_cs_lo_n (rom_cs_lo_n_o),
        .rom_cs_hi_n (rom_cs_hi_n_o),
        .ram_cs_lo_n (ram_cs_lo_n_o),
        .ram_cs_hi_n (ram_cs_hi_n_o),
        .decode_err  (decode_err_o)
    );

    // Lane report straight to the ports.
    always_comb begin
        lane_lo_o = lanes.lo;
        lane_hi_o = lanes.hi;
    end

    // Count of pairs with any select low, for the assertions.
    logic [NUM_RAM:0] pair_act;
    always_comb begin
        pair_act[NUM_RAM] = !rom_cs_lo_n_o || !rom_cs_hi_n_o;
        for (int k = 0; k < NUM_RAM; k++)
            pair_act[k] = !ram_cs_lo_n_o[k] || !ram_cs_hi_n_o[k];
    end

    // Port-level checks on the combined outputs.
    always_comb begin
        p_even_key_r1: assert (!(addr_i[0] && (!rom_cs_lo_n_o || !(&ram_cs_lo_n_o))));
        p_odd_key_r2: assert (!(bhe_n_i && (!rom_cs_hi_n_o || !(&ram_cs_hi_n_o))));
        p_err_quiet_r7: assert (!(decode_err_o && (|pair_act)));
        p_idle_quiet_r8: assert (!(rd_n_i && wr_n_i && ((|pair_act) || decode_err_o)));
        p_one_pair_r10: assert ($onehot0(pair_act));
    end
endmodule

// File: tb/memdec_top_test.sv
module memdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr_i = '0;
    logic        bhe_n_i = 1'b1;
    logic        rd_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic [14:0] chip_addr_o;
    logic        rom_cs_lo_n_o, rom_cs_hi_n_o;
    logic [1:0]  ram_cs_lo_n_o, ram_cs_hi_n_o;
    logic        lane_lo_o, lane_hi_o, decode_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    memdec_top uut (
        .addr_i        (addr_i),
        .bhe_n_i       (bhe_n_i),
        .rd_n_i        (rd_n_i),
        .wr_n_i        (wr_n_i),
        .chip_addr_o   (chip_addr_o),
        .rom_cs_lo_n_o (rom_cs_lo_n_o),
        .rom_cs_hi_n_o (rom_cs_hi_n_o),
        .ram_cs_lo_n_o (ram_cs_lo_n_o),
        .ram_cs_hi_n_o (ram_cs_hi_n_o),
        .lane_lo_o     (lane_lo_o),
        .lane_hi_o     (lane_hi_o),
        .decode_err_o  (decode_err_o)
    );

    // Vector layout:
    //   [31:12] address
    //   [11]    bhe_n
    //   [10]    rd_n
    //   [9]     wr_n
    //   [8:3]   selects {rom_hi, rom_lo, ram1_hi, ram1_lo, ram0_hi, ram0_lo}
    //   [2:1]   lanes {hi, lo}
    //   [0]     error
    localparam int NV = 16;
    localparam logic [31:0] VECS [NV] = '{
        {20'hFFFF0, 3'b001, 6'b00_11_11, 2'b11, 1'b0}, // R4 reset fetch
        {20'hF0001, 3'b001, 6'b01_11_11, 2'b10, 1'b0}, // R4 odd byte
        {20'hF0000, 3'b101, 6'b10_11_11, 2'b01, 1'b0}, // R4 even byte
        {20'hD1234, 3'b010, 6'b11_11_00, 2'b11, 1'b0}, // R5 write word
        {20'hD8001, 3'b010, 6'b11_11_01, 2'b10, 1'b0}, // R5 odd write
        {20'hE0000, 3'b101, 6'b11_10_11, 2'b01, 1'b0}, // R5 even read
        {20'hEFFFE, 3'b001, 6'b11_00_11, 2'b11, 1'b0}, // R5 top of pair 1
        {20'hDFFFF, 3'b101, 6'b11_11_11, 2'b00, 1'b0}, // R10 no lane
        {20'hF4000, 3'b010, 6'b11_11_11, 2'b11, 1'b1}, // R6 ROM write
        {20'h00000, 3'b001, 6'b11_11_11, 2'b11, 1'b1}, // R7 low hole
        {20'hCFFFF, 3'b001, 6'b11_11_11, 2'b10, 1'b1}, // R7 just below RAM
        {20'hE5550, 3'b011, 6'b11_11_11, 2'b11, 1'b0}, // R8 idle in RAM
        {20'hFFFF0, 3'b011, 6'b11_11_11, 2'b11, 1'b0}, // R8 idle in ROM
        {20'h80000, 3'b111, 6'b11_11_11, 2'b01, 1'b0}, // R8 idle unmapped
        {20'hD0000, 3'b000, 6'b11_11_00, 2'b11, 1'b0}, // R5 both strobes
        {20'hF0000, 3'b000, 6'b11_11_11, 2'b11, 1'b1}  // R6 both strobes on ROM
    };

    // Drive away from the rising edge, then let the logic settle.
    task automatic apply(input logic [19:0] a, input logic b, input logic r, input logic w);
        @(negedge clk);
        addr_i = a; bhe_n_i = b; rd_n_i = r; wr_n_i = w;
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, addr_i, got, exp);
        end
    endtask

    function automatic logic [5:0] sels();
        return {rom_cs_hi_n_o, rom_cs_lo_n_o, ram_cs_hi_n_o[1], ram_cs_lo_n_o[1],
                ram_cs_hi_n_o[0], ram_cs_lo_n_o[0]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Quiescent state: R8, all selects high, no error.
        apply(20'h00000, 1'b1, 1'b1, 1'b1);
        check("R8 quiescent", {26'd0, sels()}, {26'd0, 6'b111111});
        check("R8 quiescent err", {31'd0, decode_err_o}, 32'd0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][31:12], VECS[i][11], VECS[i][10], VECS[i][9]);
            check("R1 R2 R4 R5 R6 R7 R8 R10 selects",
                  {26'd0, sels()}, {26'd0, VECS[i][8:3]});
            check("R3 lanes", {30'd0, lane_hi_o, lane_lo_o}, {30'd0, VECS[i][2:1]});
            check("R6 R7 error", {31'd0, decode_err_o}, {31'd0, VECS[i][0]});
            check("R9 chip address", {17'd0, chip_addr_o}, {17'd0, VECS[i][27:13]});
        end

        // Boundary sweep: read word at last/first byte pair of each window edge.
        for (int t = 12; t < 16; t++) begin
            logic [19:0] base;
            logic [5:0]  exp;
            base = 20'(t) << 16;
            case (t)
                13:      exp = 6'b11_11_00;
                14:      exp = 6'b11_00_11;
                15:      exp = 6'b00_11_11;
                default: exp = 6'b11_11_11;
            endcase
            apply(base, 1'b0, 1'b0, 1'b1);
            check("R5 R4 R7 window start", {26'd0, sels()}, {26'd0, exp});
            apply(base | 20'h0FFFE, 1'b0, 1'b0, 1'b1);
            check("R5 R4 R7 window end", {26'd0, sels()}, {26'd0, exp});
            check("R7 edge error", {31'd0, decode_err_o}, {31'd0, (t == 12)});
        end

        // R3: lanes ignore the strobes (odd address, idle bus).
        apply(20'hD0003, 1'b0, 1'b1, 1'b1);
        check("R3 lanes idle", {30'd0, lane_hi_o, lane_lo_o}, {30'd0, 2'b10});
        check("R9 chip address idle", {17'd0, chip_addr_o}, {17'd0, 15'h0001});

        finish_run();
    end
endmodule